// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is the configuration window of a multi-function peripheral controller. The host sees it as two byte-wide locations: an index port and a data port. The window starts closed. To open it, the host writes the variant's entry key to the index port twice in a row. An instance built with a different key value stays closed when it sees this key, which lets two variants of the controller share the same bus location.

While the window is open, each byte written to the index port selects a register. The data port then reads or writes that register. A bank of writable configuration bytes sits at the low indices. Two fixed indices return a read-only device identifier and a read-only revision byte. Writing the exit code to the index port closes the window again.

The configuration bytes are exported as one flat bus, so neighbouring logic can decode enables and address choices from them. Reset values come from a parameter, and reset always leaves the window closed.

Top module: `cfg_unlock_port`

## Requirements
- R1: After reset the window is closed (`cfg_mode` = 0), `bus_rdata` is 0xFF, and byte i of `cfg_bytes` (bits 8i+7..8i) equals byte i of the `RESET_VALS` parameter.
- R2: Two index-port writes of `ENTRY_KEY` with no other index-port write between them open the window. `cfg_mode` is 1 in the cycle after the second write. A single key write leaves it closed.
- R3: Index-port writes of any other value, including the key of the other variant, never open the window.
- R4: An index-port write of a non-key value after one key write restarts the sequence, so the next key write is only the first of a new pair.
- R5: While open, an index-port write other than `EXIT_CODE` sets the index. A data-port read (`bus_port` = 1) puts the selected byte on `bus_rdata` one cycle later. Opening the window resets the index to 0.
- R6: While open, a data-port write to an index below `NUM_REGS` updates that configuration byte in `cfg_bytes` one cycle later.
- R7: Index 0x0D reads `CHIP_ID` and index 0x0E reads `CHIP_REV`. Data-port writes at these indices change nothing.
- R8: Other indices at or above `NUM_REGS` read 0x00, and data-port writes to them change nothing.
- R9: An index-port write of `EXIT_CODE` while open closes the window in the next cycle.
- R10: While closed, data-port reads return 0xFF and data-port writes leave `cfg_bytes` unchanged. Index-port reads (`bus_port` = 0) always return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_port | input | 1 | 0 selects the index port, 1 the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after `bus_rd` |
| cfg_mode | output | 1 | High while the window is open |
| cfg_bytes | output | NUM_REGS*8 | Configuration bytes, byte i at bits 8i+7..8i |

## Verification
The bench targets the unlock sequence at its edges. It sends the wrong variant's key twice, which a decoder that accepts any repeated byte would wrongly take as an unlock. It sends a key, then a stray byte, then a key, which a design that only counts key writes would treat as a complete pair. After the exit code it sends a lone key, which a design that keeps a stale half-sequence would accept. Inside the window, it writes to the identifier index and to the first index past the bank, which would show up as a corrupted identifier or as a write that wraps into a low register. Closed-window reads and writes check that nothing leaks through while the port is locked.

// File: rtl/cup_pkg.sv
package cup_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_OPEN  = 2'd2
    } seq_state_e;

    localparam logic [7:0] ID_INDEX    = 8'h0D;
    localparam logic [7:0] REV_INDEX   = 8'h0E;
    localparam logic [7:0] LOCKED_READ = 8'hFF;
    localparam logic [7:0] VOID_READ   = 8'h00;

    typedef struct packed {
        seq_state_e st;
    } seq_reg_t;

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] rdata;
    } port_reg_t;

endpackage

// File: rtl/cup_unlock_seq.sv
module cup_unlock_seq
    import cup_pkg::*;
#(
    parameter logic [7:0] ENTRY_KEY = 8'h55,
    parameter logic [7:0] EXIT_CODE = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic       index_load
);

    seq_reg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sel_wr) begin
            case (s_q.st)
                SEQ_IDLE:  if (wdata == ENTRY_KEY) s_d.st = SEQ_ARMED;
                SEQ_ARMED: s_d.st = (wdata == ENTRY_KEY) ? SEQ_OPEN : SEQ_IDLE;
                SEQ_OPEN:  if (wdata == EXIT_CODE) s_d.st = SEQ_IDLE;
                default:   s_d.st = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE};
        else        s_q <= s_d;
    end

    assign unlocked   = (s_q.st == SEQ_OPEN);
    assign index_load = sel_wr && unlocked && (wdata != EXIT_CODE);

    // R2
    open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(sel_wr && wdata == ENTRY_KEY));

    // R3
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_IDLE && sel_wr && wdata != ENTRY_KEY) |=> (s_q.st == SEQ_IDLE));

    // R4
    armed_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_ARMED && sel_wr && wdata != ENTRY_KEY) |=> (s_q.st == SEQ_IDLE));

    // R9
    exit_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && sel_wr && wdata == EXIT_CODE) |=> !unlocked);

endmodule

// File: rtl/cup_cfg_bank.sv
module cup_cfg_bank #(
    parameter int                      NUM_REGS   = 8,
    parameter logic [NUM_REGS*8-1:0]   RESET_VALS = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [7:0]            widx,
    input  logic [7:0]            wdata,
    output logic [NUM_REGS*8-1:0] cfg_flat
);

    logic [7:0] regs_d [NUM_REGS];
    logic [7:0] regs_q [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_d[i] = regs_q[i];
            if (we && widx == 8'(i)) regs_d[i] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n) regs_q[i] <= RESET_VALS[i*8 +: 8];
            else        regs_q[i] <= regs_d[i];
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
        assign cfg_flat[g*8 +: 8] = regs_q[g];

        // R6
        byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && widx == 8'(g)) |=> (cfg_flat[g*8 +: 8] == $past(wdata)));
    end

endmodule

// File: rtl/cfg_unlock_port.sv
module cfg_unlock_port
    import cup_pkg::*;
#(
    parameter int                    NUM_REGS   = 8,
    parameter logic [7:0]            ENTRY_KEY  = 8'h55,
    parameter logic [7:0]            EXIT_CODE  = 8'hAA,
    parameter logic [7:0]            CHIP_ID    = 8'h65,
    parameter logic [7:0]            CHIP_REV   = 8'h02,
    parameter logic [NUM_REGS*8-1:0] RESET_VALS = 64'h8877_6655_4433_2211
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic                  bus_port,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic                  cfg_mode,
    output logic [NUM_REGS*8-1:0] cfg_bytes
);

    localparam logic [7:0] REG_LIMIT = 8'(NUM_REGS);

    logic       sel_wr;
    logic       unlocked;
    logic       index_load;
    logic       bank_we;
    logic [7:0] sel_byte;
    port_reg_t  p_d, p_q;

    assign sel_wr = bus_wr && !bus_port;

    cup_unlock_seq #(
        .ENTRY_KEY (ENTRY_KEY),
        .EXIT_CODE (EXIT_CODE)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_wr     (sel_wr),
        .wdata      (bus_wdata),
        .unlocked   (unlocked),
        .index_load (index_load)
    );

    assign bank_we = bus_wr && bus_port && unlocked && (p_q.idx < REG_LIMIT);

    cup_cfg_bank #(
        .NUM_REGS   (NUM_REGS),
        .RESET_VALS (RESET_VALS)
    ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bank_we),
        .widx     (p_q.idx),
        .wdata    (bus_wdata),
        .cfg_flat (cfg_bytes)
    );

    always_comb begin
        sel_byte = VOID_READ;
        if (p_q.idx == ID_INDEX)  sel_byte = CHIP_ID;
        if (p_q.idx == REV_INDEX) sel_byte = CHIP_REV;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (p_q.idx == 8'(i)) sel_byte = cfg_bytes[i*8 +: 8];
        end
    end

    always_comb begin
        p_d = p_q;
        if (!unlocked)       p_d.idx = '0;
        else if (index_load) p_d.idx = bus_wdata;
        if (bus_rd) begin
            if (!bus_port || !unlocked) p_d.rdata = LOCKED_READ;
            else                        p_d.rdata = sel_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '{idx: 8'h00, rdata: LOCKED_READ};
        else        p_q <= p_d;
    end

    assign bus_rdata = p_q.rdata;
    assign cfg_mode  = unlocked;

    // R10
    locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_port && !cfg_mode) |=> (bus_rdata == LOCKED_READ));

    // R10
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_port && !cfg_mode) |=> $stable(cfg_bytes));

    // R8
    range_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_port && p_q.idx >= REG_LIMIT) |=> $stable(cfg_bytes));

    // R7
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_port && cfg_mode && !bus_wr && p_q.idx == ID_INDEX)
            |=> (bus_rdata == CHIP_ID));

endmodule

// File: tb/cfg_unlock_port_tb.sv
`timescale 1ns/1ps
module cfg_unlock_port_tb_top;

    localparam int          NREG  = 8;
    localparam logic [63:0] RVALS = 64'h8877_6655_4433_2211;
    localparam logic [7:0]  KEY   = 8'h55;
    localparam logic [7:0]  OKEY  = 8'h44;
    localparam logic [7:0]  EXITC = 8'hAA;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic            bus_port = 1'b0;
    logic [7:0]      bus_wdata = 8'h00;
    logic [7:0]      bus_rdata;
    logic            cfg_mode;
    logic [NREG*8-1:0] cfg_bytes;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_seen = 1'b0;

    always #10 clk = ~clk;

    cfg_unlock_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_port  (bus_port),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_mode  (cfg_mode),
        .cfg_bytes (cfg_bytes)
    );

    always @(posedge clk) rd_seen <= bus_rd && rst_n;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s rdata actual %02h expected %02h", t, bus_rdata, e);
            end
        end
    end

    task automatic check(input string t, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", t, act, exp);
        end
    endtask

    task automatic wr(input logic port, input logic [7:0] d);
        bus_wr = 1'b1; bus_port = port; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic port, input logic [7:0] exp, input string t);
        exp_q.push_back(exp);
        tag_q.push_back(t);
        bus_rd = 1'b1; bus_port = port;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        #(20 * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] shadow;
        shadow = RVALS;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 mode", 64'(cfg_mode), 64'h0);
        check("R1 bytes", cfg_bytes, RVALS);
        check("R1 rdata", 64'(bus_rdata), 64'hFF);
        // R10 locked access
        rd(1'b1, 8'hFF, "R10 locked read");
        wr(1'b1, 8'h33);
        @(negedge clk);
        check("R10 locked write", cfg_bytes, shadow);
        // R3 other key twice
        wr(1'b0, OKEY); wr(1'b0, OKEY);
        check("R3 other key", 64'(cfg_mode), 64'h0);
        // R4 key, stray, key
        wr(1'b0, KEY);
        check("R2 single key", 64'(cfg_mode), 64'h0);
        wr(1'b0, 8'h13); wr(1'b0, KEY);
        check("R4 restart", 64'(cfg_mode), 64'h0);
        wr(1'b0, KEY);
        check("R2 unlock", 64'(cfg_mode), 64'h1);
        // R5 reads
        rd(1'b1, 8'h11, "R5 index zero after open");
        wr(1'b0, 8'h03);
        rd(1'b1, 8'h44, "R5 reg3");
        rd(1'b0, 8'hFF, "R10 index port read");
        // R6 writes
        wr(1'b0, 8'h02); wr(1'b1, 8'hC3);
        shadow[23:16] = 8'hC3;
        check("R6 cfg byte2", cfg_bytes, shadow);
        rd(1'b1, 8'hC3, "R6 readback");
        wr(1'b0, 8'h07); wr(1'b1, 8'h5A);
        shadow[63:56] = 8'h5A;
        rd(1'b1, 8'h5A, "R6 top reg");
        // R7 id / rev
        wr(1'b0, 8'h0D);
        rd(1'b1, 8'h65, "R7 id");
        wr(1'b1, 8'h00);
        rd(1'b1, 8'h65, "R7 id after write");
        check("R7 bytes unchanged", cfg_bytes, shadow);
        wr(1'b0, 8'h0E);
        rd(1'b1, 8'h02, "R7 rev");
        // R8 out of range
        wr(1'b0, 8'h08);
        rd(1'b1, 8'h00, "R8 void read");
        wr(1'b1, 8'h77);
        @(negedge clk);
        check("R8 write ignored", cfg_bytes, shadow);
        // R9 exit
        wr(1'b0, EXITC);
        check("R9 relock", 64'(cfg_mode), 64'h0);
        rd(1'b1, 8'hFF, "R10 read after exit");
        wr(1'b1, 8'h99);
        @(negedge clk);
        check("R10 write after exit", cfg_bytes, shadow);
        wr(1'b0, KEY);
        check("R2 lone key after exit", 64'(cfg_mode), 64'h0);
        wr(1'b0, KEY);
        check("R2 reopen", 64'(cfg_mode), 64'h1);
        wr(1'b0, 8'h02);
        rd(1'b1, 8'hC3, "R6 retained");
        @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule